// File: doc/BRIEF.md
# Dual-Pointer Video Memory Access Port

This block is the host-facing register front end of a video memory. A byte-wide host bus reaches a small window of registers, addressed by a 5-bit offset and qualified by chip-select, read and write strobes. Through this window the host can move bytes in and out of a 17-bit video RAM without issuing a full address for every byte. Two independent pointers are held inside the block. Each pointer has a data port of its own, and each carries its own step size and direction.

A single set of three address registers (low, middle, high) is shared by both pointers. A select bit in the control register chooses which pointer these registers show. The data ports do not follow the select bit: port 0 always works at pointer 0 and port 1 always at pointer 1. Every data-port access moves its pointer by the programmed amount, modulo 2^17. A write to a data port queues a memory write. A read from a data port returns a byte that was fetched ahead of time, so host reads never wait on the memory.

Toward the video RAM the block issues one request at a time on a simple synchronous port. A request is held unchanged until the memory grants it. Read data comes back on the cycle after the grant.

Top module: `vram_dual_port`

## Requirements
- R1: After reset both pointers, both step codes, both decrement flags, the select bit and both prefetched bytes are zero, so every register offset reads 0x00.
- R2: The control register is at offset 5. Its bit 0 is the select bit and bits 7:1 read as zero. The select bit decides whether offsets 0 (bits 7:0), 1 (bits 15:8) and 2 (high register) read and write pointer 0 or pointer 1.
- R3: The high register at offset 2 reads as {step code[7:4], decrement[3], 2'b00, pointer bit 16[0]}. Writes store bits 7:4, 3 and 0 into the selected pointer's state. Bits 2:1 are ignored on write and read as zero.
- R4: The data port at offset 3 uses pointer 0 and the data port at offset 4 uses pointer 1, whatever the select bit holds.
- R5: A data-port access moves its pointer by a step of 0 for code 0, and by 2^(code-1) for codes 1 to 15. The arithmetic wraps modulo 2^17.
- R6: When the pointer's decrement flag is set, the pointer moves down by the step instead of up, with the same wrap.
- R7: A host read of a data port returns that port's prefetched byte. The pointer then steps, and the byte at the new pointer is fetched into the prefetch register.
- R8: A host write to a data port stores the byte in memory at the pointer's current value. The pointer then steps, and the byte at the new pointer is prefetched.
- R9: A host write to any of offsets 0, 1 or 2 starts a fresh prefetch for the selected pointer. A following read of that pointer's port returns memory at the new address.
- R10: While mem_req is high and mem_gnt is low, mem_req stays high and mem_we, mem_addr and mem_wdata hold their values.
- R11: Offsets 6 to 31 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Chip select for the register window |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_off | input | 5 | Register offset within the window |
| host_wdata | input | 8 | Write data from the host |
| host_rdata | output | 8 | Read data, valid while a read is strobed |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 17 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_rdata | input | 8 | Read data, valid the cycle after a read grant |

## Verification
The bench builds the block with its default parameters: a 17-bit address and a 4-bit step code. This size is needed to reach the wrap of the address at both ends and the largest step of 16384. Its memory model aliases the address onto a 4096-byte array and applies the same aliasing in its reference. The full 17-bit pointer range can therefore be exercised while the results stay checkable. The grant is withheld at random, which drives the request-holding and write-before-fetch ordering through many stall patterns.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
    localparam int unsigned OFF_LO   = 0;
    localparam int unsigned OFF_MID  = 1;
    localparam int unsigned OFF_HI   = 2;
    localparam int unsigned OFF_DP0  = 3;
    localparam int unsigned OFF_DP1  = 4;
    localparam int unsigned OFF_CTRL = 5;
    localparam int unsigned NPORT    = 2;
endpackage

// File: rtl/vpf_stepper.sv
module vpf_stepper #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned CODE_W = 4
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [CODE_W-1:0] code,
    input  logic              down,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] amt;
    logic [CODE_W-1:0] shamt;

    always_comb begin
        shamt = code - CODE_W'(1);
        amt   = (code == '0) ? '0 : (ADDR_W'(1) << shamt);
        nxt   = down ? (ptr - amt) : (ptr + amt);
    end
endmodule

// File: rtl/vpf_arb.sv
module vpf_arb (
    input  logic [1:0] pend_wr,
    input  logic [1:0] pend_fetch,
    output logic       pick_v,
    output logic       pick_wr,
    output logic       pick_port
);
    // writes go ahead of fetches so a fetch never reads stale memory
    always_comb begin
        pick_v    = 1'b1;
        pick_wr   = 1'b0;
        pick_port = 1'b0;
        if (pend_wr[0]) begin
            pick_wr = 1'b1;
        end else if (pend_wr[1]) begin
            pick_wr   = 1'b1;
            pick_port = 1'b1;
        end else if (pend_fetch[0]) begin
            pick_port = 1'b0;
        end else if (pend_fetch[1]) begin
            pick_port = 1'b1;
        end else begin
            pick_v = 1'b0;
        end
    end
endmodule

// File: rtl/vram_dual_port.sv
module vram_dual_port #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OFF_W  = 5,
    parameter int unsigned CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata
);
    import vpf_pkg::*;

    localparam int unsigned TOP_BIT = ADDR_W - 1;
    localparam int unsigned DEC_BIT = 3;
    localparam int unsigned PAD_W   = DATA_W - CODE_W - 2;

    typedef struct packed {
        logic [NPORT-1:0][ADDR_W-1:0] ptr;
        logic [NPORT-1:0][CODE_W-1:0] code;
        logic [NPORT-1:0]             down;
        logic                         sel;
        logic [NPORT-1:0][DATA_W-1:0] pre;
        logic [NPORT-1:0]             pend_wr;
        logic [NPORT-1:0][ADDR_W-1:0] wr_addr;
        logic [NPORT-1:0][DATA_W-1:0] wr_data;
        logic [NPORT-1:0]             pend_fetch;
        logic                         out_v;
        logic                         out_we;
        logic                         out_port;
        logic [ADDR_W-1:0]            out_addr;
        logic [DATA_W-1:0]            out_data;
        logic                         tag_v;
        logic                         tag_port;
    } state_t;

    state_t state_d, state_q;

    logic [NPORT-1:0][ADDR_W-1:0] step_nxt;
    logic pick_v, pick_wr, pick_port;

    for (genvar g = 0; g < NPORT; g++) begin : g_step
        vpf_stepper #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_step (
            .ptr  (state_q.ptr[g]),
            .code (state_q.code[g]),
            .down (state_q.down[g]),
            .nxt  (step_nxt[g])
        );
    end

    vpf_arb u_arb (
        .pend_wr    (state_q.pend_wr),
        .pend_fetch (state_q.pend_fetch),
        .pick_v     (pick_v),
        .pick_wr    (pick_wr),
        .pick_port  (pick_port)
    );

    logic do_wr, do_rd;
    assign do_wr = host_cs && host_wr;
    assign do_rd = host_cs && host_rd && !host_wr;

    always_comb begin
        state_d = state_q;

        // return path of an earlier read grant
        state_d.tag_v    = state_q.out_v && mem_gnt && !state_q.out_we;
        state_d.tag_port = state_q.out_port;
        if (state_q.tag_v) begin
            state_d.pre[state_q.tag_port] = mem_rdata;
        end

        // refill the request slot when it is empty or just accepted
        if (!state_q.out_v || mem_gnt) begin
            state_d.out_v    = pick_v;
            state_d.out_we   = pick_wr;
            state_d.out_port = pick_port;
            state_d.out_addr = pick_wr ? state_q.wr_addr[pick_port] : state_q.ptr[pick_port];
            state_d.out_data = state_q.wr_data[pick_port];
            if (pick_v && pick_wr) begin
                state_d.pend_wr[pick_port] = 1'b0;
            end else if (pick_v) begin
                state_d.pend_fetch[pick_port] = 1'b0;
            end
        end

        // host side; sets made here win over the clears above
        if (do_wr) begin
            case (host_off)
                OFF_W'(OFF_LO): begin
                    state_d.ptr[state_q.sel][7:0]      = host_wdata;
                    state_d.pend_fetch[state_q.sel]    = 1'b1;
                end
                OFF_W'(OFF_MID): begin
                    state_d.ptr[state_q.sel][15:8]     = host_wdata;
                    state_d.pend_fetch[state_q.sel]    = 1'b1;
                end
                OFF_W'(OFF_HI): begin
                    state_d.ptr[state_q.sel][TOP_BIT]  = host_wdata[0];
                    state_d.down[state_q.sel]          = host_wdata[DEC_BIT];
                    state_d.code[state_q.sel]          = host_wdata[DATA_W-1 -: CODE_W];
                    state_d.pend_fetch[state_q.sel]    = 1'b1;
                end
                OFF_W'(OFF_DP0), OFF_W'(OFF_DP1): begin
                    state_d.pend_wr[host_off[0] ? 0 : 1]    = 1'b1;
                    state_d.wr_addr[host_off[0] ? 0 : 1]    = state_q.ptr[host_off[0] ? 0 : 1];
                    state_d.wr_data[host_off[0] ? 0 : 1]    = host_wdata;
                    state_d.ptr[host_off[0] ? 0 : 1]        = step_nxt[host_off[0] ? 0 : 1];
                    state_d.pend_fetch[host_off[0] ? 0 : 1] = 1'b1;
                end
                OFF_W'(OFF_CTRL): begin
                    state_d.sel = host_wdata[0];
                end
                default: ;
            endcase
        end else if (do_rd && (host_off == OFF_W'(OFF_DP0) || host_off == OFF_W'(OFF_DP1))) begin
            state_d.ptr[host_off[0] ? 0 : 1]        = step_nxt[host_off[0] ? 0 : 1];
            state_d.pend_fetch[host_off[0] ? 0 : 1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (do_rd) begin
            case (host_off)
                OFF_W'(OFF_LO):   host_rdata = state_q.ptr[state_q.sel][7:0];
                OFF_W'(OFF_MID):  host_rdata = state_q.ptr[state_q.sel][15:8];
                OFF_W'(OFF_HI):   host_rdata = {state_q.code[state_q.sel], state_q.down[state_q.sel],
                                                PAD_W'(0), state_q.ptr[state_q.sel][TOP_BIT]};
                OFF_W'(OFF_DP0):  host_rdata = state_q.pre[0];
                OFF_W'(OFF_DP1):  host_rdata = state_q.pre[1];
                OFF_W'(OFF_CTRL): host_rdata = {(DATA_W-1)'(0), state_q.sel};
                default:          host_rdata = '0;
            endcase
        end
    end

    assign mem_req   = state_q.out_v;
    assign mem_we    = state_q.out_we;
    assign mem_addr  = state_q.out_addr;
    assign mem_wdata = state_q.out_data;
endmodule

// File: rtl/vram_dual_port_chk.sv
module vram_dual_port_chk #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OFF_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_cs,
    input logic              host_rd,
    input logic              host_wr,
    input logic [OFF_W-1:0]  host_off,
    input logic [DATA_W-1:0] host_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_gnt
);
    logic rd_only;
    assign rd_only = host_cs && host_rd && !host_wr;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R10

    AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only && host_off == OFF_W'(2) |-> host_rdata[2:1] == 2'b00); // R3

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only && host_off == OFF_W'(5) |-> host_rdata[DATA_W-1:1] == '0); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only && host_off > OFF_W'(5) |-> host_rdata == '0); // R11

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cs |-> host_rdata == '0); // R11
endmodule

bind vram_dual_port vram_dual_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_cs    (host_cs),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_off   (host_off),
    .host_rdata (host_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt)
);

// File: tb/vram_dual_port_tb.sv
module vram_dual_port_tb;
    localparam int unsigned AW = 17;
    localparam int unsigned MW = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [4:0]  host_off = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        mem_req, mem_we, mem_gnt;
    logic [AW-1:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int unsigned n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vram_dual_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
        .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    // bench memory, aliased onto MW bytes
    logic [7:0] bmem [MW];
    always @(posedge clk) begin
        if (mem_req && mem_gnt) begin
            if (mem_we) bmem[mem_addr[11:0]] <= mem_wdata;
            else        mem_rdata <= bmem[mem_addr[11:0]];
        end
    end
    always @(negedge clk) mem_gnt <= ($urandom % 4) != 0;

    // reference model
    logic [AW-1:0] rptr [2];
    logic [3:0]    rcode [2];
    logic          rdown [2];
    logic          rsel;
    logic [7:0]    rpre [2];
    logic [7:0]    rmem [MW];

    function automatic logic [AW-1:0] ref_step(logic [AW-1:0] p, logic [3:0] c, logic dn);
        logic [AW-1:0] a;
        a = (c == 0) ? '0 : AW'(1 << (c - 1));
        return dn ? p - a : p + a;
    endfunction

    function automatic logic [7:0] ref_read(logic [4:0] off);
        case (off)
            5'd0: return rptr[rsel][7:0];
            5'd1: return rptr[rsel][15:8];
            5'd2: return {rcode[rsel], rdown[rsel], 2'b00, rptr[rsel][16]};
            5'd3: return rpre[0];
            5'd4: return rpre[1];
            5'd5: return {7'd0, rsel};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (40) @(posedge clk);
    endtask

    task automatic host_write(logic [4:0] off, logic [7:0] d);
        logic p;
        @(negedge clk);
        host_cs = 1; host_wr = 1; host_off = off; host_wdata = d;
        @(negedge clk);
        host_cs = 0; host_wr = 0;
        case (off)
            5'd0: begin rptr[rsel][7:0] = d;  rpre[rsel] = rmem[rptr[rsel][11:0]]; end
            5'd1: begin rptr[rsel][15:8] = d; rpre[rsel] = rmem[rptr[rsel][11:0]]; end
            5'd2: begin
                rptr[rsel][16] = d[0]; rdown[rsel] = d[3]; rcode[rsel] = d[7:4];
                rpre[rsel] = rmem[rptr[rsel][11:0]];
            end
            5'd3, 5'd4: begin
                p = (off == 5'd4);
                rmem[rptr[p][11:0]] = d;
                rptr[p] = ref_step(rptr[p], rcode[p], rdown[p]);
                rpre[p] = rmem[rptr[p][11:0]];
            end
            5'd5: rsel = d[0];
            default: ;
        endcase
        settle();
    endtask

    task automatic host_read(logic [4:0] off, string req);
        logic p;
        logic [7:0] exp;
        exp = ref_read(off);
        @(negedge clk);
        host_cs = 1; host_rd = 1; host_off = off;
        #5;
        check(req, host_rdata, exp);
        @(negedge clk);
        host_cs = 0; host_rd = 0;
        if (off == 5'd3 || off == 5'd4) begin
            p = (off == 5'd4);
            rptr[p] = ref_step(rptr[p], rcode[p], rdown[p]);
            rpre[p] = rmem[rptr[p][11:0]];
        end
        settle();
    endtask

    task automatic set_ptr(logic s, logic [AW-1:0] a, logic [3:0] c, logic dn);
        host_write(5'd5, {7'd0, s});
        host_write(5'd0, a[7:0]);
        host_write(5'd1, a[15:8]);
        host_write(5'd2, {c, dn, 2'b00, a[16]});
    endtask

    initial begin
        for (int i = 0; i < MW; i++) begin
            bmem[i] = 8'((i * 37 + 11) ^ (i >> 4));
            rmem[i] = bmem[i];
        end
        for (int i = 0; i < 2; i++) begin
            rptr[i] = '0; rcode[i] = '0; rdown[i] = 0; rpre[i] = '0;
        end
        rsel = 0;
        repeat (4) @(posedge clk);
        rst_n = 1;

        // R1 reset state
        for (int o = 0; o < 6; o++) host_read(5'(o), "R1");

        // R2 banking of address registers
        set_ptr(0, 17'h00123, 4'd1, 0);
        set_ptr(1, 17'h10456, 4'd2, 1);
        host_write(5'd5, 8'h00);
        host_read(5'd0, "R2");
        host_read(5'd1, "R2");
        host_write(5'd5, 8'hFF);
        host_read(5'd5, "R2");
        host_read(5'd0, "R2");
        host_read(5'd2, "R3");

        // R3 pad bits ignored on write
        host_write(5'd2, 8'h76);
        host_read(5'd2, "R3");

        // R4 ports ignore select; R7 read returns prefetch then steps
        host_write(5'd5, 8'h01);
        host_read(5'd3, "R4");
        host_read(5'd4, "R4");
        host_read(5'd3, "R7");
        host_write(5'd5, 8'h00);
        host_read(5'd0, "R7");

        // R5 largest step wraps upward
        set_ptr(0, 17'h1FFFF, 4'd15, 0);
        host_read(5'd3, "R5");
        host_read(5'd0, "R5");
        host_read(5'd1, "R5");
        host_read(5'd2, "R5");

        // R6 decrement wraps below zero
        set_ptr(0, 17'h00000, 4'd1, 1);
        host_read(5'd3, "R6");
        host_read(5'd0, "R6");
        host_read(5'd1, "R6");
        host_read(5'd2, "R6");

        // R8 write, then R9 re-point and read back
        set_ptr(1, 17'h00200, 4'd1, 0);
        host_write(5'd4, 8'hA5);
        host_write(5'd4, 8'h5A);
        host_read(5'd4, "R8");
        set_ptr(1, 17'h00200, 4'd1, 0);
        host_read(5'd4, "R9");
        host_read(5'd4, "R9");

        // R11 unmapped offsets
        host_write(5'd7, 8'hFF);
        host_write(5'd31, 8'h01);
        host_read(5'd7, "R11");
        host_read(5'd31, "R11");
        host_read(5'd5, "R11");
        host_read(5'd0, "R11");

        // random mix against the model
        for (int k = 0; k < 600; k++) begin
            int unsigned op;
            op = $urandom % 10;
            case (op)
                0: host_write(5'd5, 8'($urandom));
                1: host_write(5'($urandom % 3), 8'($urandom));
                2, 3: host_write(5'(3 + $urandom % 2), 8'($urandom));
                4, 5, 6: host_read(5'(3 + $urandom % 2), "R7");
                7: host_read(5'($urandom % 3), "R2");
                8: host_read(5'($urandom % 3), "R5");
                default: host_read(5'(6 + $urandom % 26), "R11");
            endcase
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule